// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block turns a pixel clock into the raster timing for a display link. Every
window is given at run time as a begin and an end position:

- The active window, the horizontal sync window and the vertical sync window.
- Positions are counted in pixels from the start of a line, or in lines from the
  start of a frame.
- The last pixel position of the active window also sets the line length.

From these the block produces horizontal sync, vertical sync, data enable and a
field flag. Alongside them it reports the pixel and line position that these
outputs describe.

In progressive operation one set of vertical windows describes the whole frame.
With interlace selected, the frame is split into two fields, and each field has
its own active-line window and vertical-sync window. In the second field, vertical
sync does not change at the start of a line. It changes at a programmable pixel
inside the line, given as an offset from the start of horizontal sync, which
produces the half-line sync shift that interlaced formats need.

The parameter set is copied into shadow registers. It is copied on every cycle
while the generator is stopped, and once per frame while it runs, so a change
made mid-frame only takes effect from the next frame.

Top module: `raster_timing_gen`

## Requirements
- R1: While running, `pix_o` counts 0,1,...,`act_h_stop`-1 and then wraps to 0; `line_o` advances by one at each wrap. So the line length is `act_h_stop` pixels.
- R2: `de_o` is 1 exactly when `pix_o` is in [`act_h_start`, `act_h_stop`) and `line_o` is an active line. In progressive mode, active lines are [`f0_act_start`, `f0_act_stop`). In interlaced mode, they are that window or [`f1_act_start`, `f1_act_stop`).
- R3: Horizontal sync is active for `pix_o` in [`hs_start`, `hs_stop`). `hsync_o` equals the active flag XOR `hs_inv`, so 0 means active-high and 1 means active-low.
- R4: In progressive mode (`ilace_en`=0) the frame has `f0_act_stop` lines. Vertical sync is active on lines [`f0_vs_start`, `f0_vs_stop`), starting at pixel 0. `vsync_o` equals the active flag XOR `vs_inv`.
- R5: In interlaced mode (`ilace_en`=1) the frame has `f1_act_stop` lines. `field_o` is 0 (first field) on lines below `f0_act_stop` and 1 (second field) from that line to the end of the frame; in progressive mode it stays 0.
- R6: In interlaced mode vertical sync is also active between the two positions (line `f1_vs_start`, pixel M) and (line `f1_vs_stop`, pixel M). Here M = `hs_start` + `f1_vs_shift`. The start position is included and the end position is not, so in the second field vertical sync changes at pixel M and not at pixel 0.
- R7: A parameter change made while running has no effect until the frame in progress ends. The next frame uses the new values, so no line or frame is cut short.
- R8: While `gen_en` is 0:
  - `de_o`, `field_o`, `pix_o` and `line_o` are 0.
  - `hsync_o` and `vsync_o` sit at their inactive levels (`hs_inv`, `vs_inv`).
  - After `gen_en` rises, the first reported position is pixel 0 of line 0.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Runs the counters when 1 |
| ilace_en | input | 1 | 1 selects two-field interlaced frames |
| hs_inv | input | 1 | Horizontal sync polarity (1 = active-low) |
| vs_inv | input | 1 | Vertical sync polarity (1 = active-low) |
| act_h_start | input | HW | First active pixel |
| act_h_stop | input | HW | End of active pixels and line length |
| hs_start | input | HW | First horizontal sync pixel |
| hs_stop | input | HW | End of horizontal sync |
| f0_act_start | input | VW | First active line of the first field or frame |
| f0_act_stop | input | VW | End of first-field active lines; progressive frame length |
| f0_vs_start | input | VW | First vertical sync line, first field |
| f0_vs_stop | input | VW | End of vertical sync, first field |
| f1_act_start | input | VW | First active line of the second field |
| f1_act_stop | input | VW | End of second-field active lines; interlaced frame length |
| f1_vs_start | input | VW | Second-field vertical sync start line |
| f1_vs_stop | input | VW | Second-field vertical sync end line |
| f1_vs_shift | input | HW | Pixel offset from `hs_start` of the second-field sync edges |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Field flag (0 first, 1 second) |
| pix_o | output | HW | Pixel position of the current outputs |
| line_o | output | VW | Line position of the current outputs |

## Verification
Random parameter sets switch between progressive and interlaced frames. Each set uses random line lengths, window positions, sync polarities and half-line offsets, so that errors in window bounds, in polarity and in field selection show up as different outputs. Some sets are applied while the generator runs and some after a short stop, which separates shadowed capture at the frame boundary from immediate capture. Directed interlaced probes sample the pixel just before and the pixel at the mid-line offset, on the second field's first and last sync lines, and these tell a mid-line sync edge from one at the line start. A directed mid-frame shrink of the line length shows whether the running frame keeps its old length.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // Widest counter handled by the shared window compare.
  localparam int unsigned WIN_W = 16;

  // Half-open window test: beg <= pos < fin.
  function automatic logic in_win(input logic [WIN_W-1:0] pos,
                                  input logic [WIN_W-1:0] beg,
                                  input logic [WIN_W-1:0] fin);
    return (pos >= beg) && (pos < fin);
  endfunction
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q_r;
    if (load) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] line_len,
  input  logic [VW-1:0] frame_len,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          frame_end_o
);
  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          line_end;

  always_comb begin
    line_end    = (h_q >= (line_len - 1'b1));
    frame_end_o = line_end && (v_q >= (frame_len - 1'b1));
    h_d = h_q;
    v_d = v_q;
    if (!run) begin
      h_d = '0;
      v_d = '0;
    end else if (line_end) begin
      h_d = '0;
      v_d = frame_end_o ? '0 : (v_q + 1'b1);
    end else begin
      h_d = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ilace,
  input  logic          hinv,
  input  logic          vinv,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  input  logic [HW-1:0] ah_beg,
  input  logic [HW-1:0] ah_end,
  input  logic [HW-1:0] hs_beg,
  input  logic [HW-1:0] hs_end,
  input  logic [HW-1:0] vs_shift,
  input  logic [VW-1:0] a0_beg,
  input  logic [VW-1:0] a0_end,
  input  logic [VW-1:0] s0_beg,
  input  logic [VW-1:0] s0_end,
  input  logic [VW-1:0] a1_beg,
  input  logic [VW-1:0] a1_end,
  input  logic [VW-1:0] s1_beg,
  input  logic [VW-1:0] s1_end,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          field_o,
  output logic [HW-1:0] pix_o,
  output logic [VW-1:0] line_o
);
  localparam int unsigned HX = HW + 1;

  logic [HX-1:0] mid_pos;
  logic          past_mid;
  logic          hs_act, de_act, vs0_act, vs1_act, vs_act, fld_act;
  logic          line_on0, line_on1, after_beg, before_end;

  logic          hs_q, vs_q, de_q, fld_q;
  logic          hs_d, vs_d, de_d, fld_d;
  logic [HW-1:0] pix_q, pix_d;
  logic [VW-1:0] line_q, line_d;

  always_comb begin
    mid_pos    = {1'b0, hs_beg} + {1'b0, vs_shift};
    past_mid   = ({1'b0, h} >= mid_pos);
    hs_act     = in_win(WIN_W'(h), WIN_W'(hs_beg), WIN_W'(hs_end));
    line_on0   = in_win(WIN_W'(v), WIN_W'(a0_beg), WIN_W'(a0_end));
    line_on1   = ilace && in_win(WIN_W'(v), WIN_W'(a1_beg), WIN_W'(a1_end));
    de_act     = in_win(WIN_W'(h), WIN_W'(ah_beg), WIN_W'(ah_end)) &&
                 (line_on0 || line_on1);
    vs0_act    = in_win(WIN_W'(v), WIN_W'(s0_beg), WIN_W'(s0_end));
    after_beg  = (v > s1_beg) || ((v == s1_beg) && past_mid);
    before_end = (v < s1_end) || ((v == s1_end) && !past_mid);
    vs1_act    = ilace && after_beg && before_end;
    vs_act     = vs0_act || vs1_act;
    fld_act    = ilace && (v >= a0_end);
  end

  always_comb begin
    if (run) begin
      hs_d   = hs_act ^ hinv;
      vs_d   = vs_act ^ vinv;
      de_d   = de_act;
      fld_d  = fld_act;
      pix_d  = h;
      line_d = v;
    end else begin
      hs_d   = hinv;
      vs_d   = vinv;
      de_d   = 1'b0;
      fld_d  = 1'b0;
      pix_d  = '0;
      line_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      de_q   <= 1'b0;
      fld_q  <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      hs_q   <= hs_d;
      vs_q   <= vs_d;
      de_q   <= de_d;
      fld_q  <= fld_d;
      pix_q  <= pix_d;
      line_q <= line_d;
    end
  end

  assign hsync_o = hs_q;
  assign vsync_o = vs_q;
  assign de_o    = de_q;
  assign field_o = fld_q;
  assign pix_o   = pix_q;
  assign line_o  = line_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic          ilace_en,
  input  logic          hs_inv,
  input  logic          vs_inv,
  input  logic [HW-1:0] act_h_start,
  input  logic [HW-1:0] act_h_stop,
  input  logic [HW-1:0] hs_start,
  input  logic [HW-1:0] hs_stop,
  input  logic [VW-1:0] f0_act_start,
  input  logic [VW-1:0] f0_act_stop,
  input  logic [VW-1:0] f0_vs_start,
  input  logic [VW-1:0] f0_vs_stop,
  input  logic [VW-1:0] f1_act_start,
  input  logic [VW-1:0] f1_act_stop,
  input  logic [VW-1:0] f1_vs_start,
  input  logic [VW-1:0] f1_vs_stop,
  input  logic [HW-1:0] f1_vs_shift,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          field_o,
  output logic [HW-1:0] pix_o,
  output logic [VW-1:0] line_o
);
  localparam int unsigned CFG_W = 5 * HW + 8 * VW + 3;

  logic [CFG_W-1:0] cfg_live, cfg_sh;
  logic             sh_il, sh_vinv, sh_hinv;
  logic [HW-1:0]    sh_shift, sh_hs_end, sh_hs_beg, sh_ah_end, sh_ah_beg;
  logic [VW-1:0]    sh_s1_end, sh_s1_beg, sh_a1_end, sh_a1_beg;
  logic [VW-1:0]    sh_s0_end, sh_s0_beg, sh_a0_end, sh_a0_beg;
  logic [HW-1:0]    h_cnt;
  logic [VW-1:0]    v_cnt;
  logic [VW-1:0]    frame_len;
  logic             frame_end;
  logic             cfg_load;

  assign cfg_live = {ilace_en, vs_inv, hs_inv,
                     f1_vs_shift, hs_stop, hs_start, act_h_stop, act_h_start,
                     f1_vs_stop, f1_vs_start, f1_act_stop, f1_act_start,
                     f0_vs_stop, f0_vs_start, f0_act_stop, f0_act_start};

  assign {sh_il, sh_vinv, sh_hinv,
          sh_shift, sh_hs_end, sh_hs_beg, sh_ah_end, sh_ah_beg,
          sh_s1_end, sh_s1_beg, sh_a1_end, sh_a1_beg,
          sh_s0_end, sh_s0_beg, sh_a0_end, sh_a0_beg} = cfg_sh;

  // Capture freely while stopped, otherwise only on the last pixel of a frame.
  assign cfg_load  = !gen_en || frame_end;
  assign frame_len = sh_il ? sh_a1_end : sh_a0_end;

  rtg_shadow #(.W(CFG_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .d     (cfg_live),
    .q     (cfg_sh)
  );

  rtg_counter #(.HW(HW), .VW(VW)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (gen_en),
    .line_len    (sh_ah_end),
    .frame_len   (frame_len),
    .h_o         (h_cnt),
    .v_o         (v_cnt),
    .frame_end_o (frame_end)
  );

  rtg_decode #(.HW(HW), .VW(VW)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gen_en),
    .ilace    (sh_il),
    .hinv     (sh_hinv),
    .vinv     (sh_vinv),
    .h        (h_cnt),
    .v        (v_cnt),
    .ah_beg   (sh_ah_beg),
    .ah_end   (sh_ah_end),
    .hs_beg   (sh_hs_beg),
    .hs_end   (sh_hs_end),
    .vs_shift (sh_shift),
    .a0_beg   (sh_a0_beg),
    .a0_end   (sh_a0_end),
    .s0_beg   (sh_s0_beg),
    .s0_end   (sh_s0_end),
    .a1_beg   (sh_a1_beg),
    .a1_end   (sh_a1_end),
    .s1_beg   (sh_s1_beg),
    .s1_end   (sh_s1_end),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .de_o     (de_o),
    .field_o  (field_o),
    .pix_o    (pix_o),
    .line_o   (line_o)
  );
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gen_en,
  input logic          de_o,
  input logic          field_o,
  input logic [HW-1:0] pix_o,
  input logic [VW-1:0] line_o
);
  // R8: a stopped generator reports nothing active and position zero
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gen_en) |-> (!de_o && !field_o && pix_o == '0 && line_o == '0));

  // R1: inside a line the pixel position steps by one
  a_r1_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && $past(gen_en, 2) && pix_o != '0) |->
      (pix_o == $past(pix_o) + HW'(1)));

  // R4: the line position only changes at pixel zero
  a_r4_line_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && !$stable(line_o)) |-> (pix_o == '0));

  // R5: the second field begins at the start of a line
  a_r5_field_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_o) |-> (pix_o == '0));

  // R2: data enable only while running
  a_r2_de_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> $past(gen_en));
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gen_en  (gen_en),
  .de_o    (de_o),
  .field_o (field_o),
  .pix_o   (pix_o),
  .line_o  (line_o)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int WD_CYC = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b0, ilace_en = 1'b0, hs_inv = 1'b0, vs_inv = 1'b0;
  logic [HW-1:0] act_h_start = '0, act_h_stop = '0, hs_start = '0, hs_stop = '0, f1_vs_shift = '0;
  logic [VW-1:0] f0_act_start = '0, f0_act_stop = '0, f0_vs_start = '0, f0_vs_stop = '0;
  logic [VW-1:0] f1_act_start = '0, f1_act_stop = '0, f1_vs_start = '0, f1_vs_stop = '0;
  logic hsync_o, vsync_o, de_o, field_o;
  logic [HW-1:0] pix_o;
  logic [VW-1:0] line_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_timing_gen #(.HW(HW), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .ilace_en(ilace_en),
    .hs_inv(hs_inv), .vs_inv(vs_inv),
    .act_h_start(act_h_start), .act_h_stop(act_h_stop),
    .hs_start(hs_start), .hs_stop(hs_stop),
    .f0_act_start(f0_act_start), .f0_act_stop(f0_act_stop),
    .f0_vs_start(f0_vs_start), .f0_vs_stop(f0_vs_stop),
    .f1_act_start(f1_act_start), .f1_act_stop(f1_act_stop),
    .f1_vs_start(f1_vs_start), .f1_vs_stop(f1_vs_stop),
    .f1_vs_shift(f1_vs_shift),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .field_o(field_o),
    .pix_o(pix_o), .line_o(line_o)
  );

  // ---------------- reference model built from the requirements ----------
  int m_h = 0, m_v = 0;
  int s_ahb = 0, s_ahe = 0, s_hsb = 0, s_hse = 0, s_sh = 0;
  int s_a0b = 0, s_a0e = 0, s_s0b = 0, s_s0e = 0;
  int s_a1b = 0, s_a1e = 0, s_s1b = 0, s_s1e = 0;
  bit s_il = 0, s_hi = 0, s_vi = 0;
  int e_hs = 0, e_vs = 0, e_de = 0, e_fd = 0, e_pix = 0, e_line = 0;

  function automatic bit win(int p, int b, int e);
    return (p >= b) && (p < e);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0;
      s_ahb = 0; s_ahe = 0; s_hsb = 0; s_hse = 0; s_sh = 0;
      s_a0b = 0; s_a0e = 0; s_s0b = 0; s_s0e = 0;
      s_a1b = 0; s_a1e = 0; s_s1b = 0; s_s1e = 0;
      s_il = 0; s_hi = 0; s_vi = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_fd = 0; e_pix = 0; e_line = 0;
    end else begin
      bit lend, fend, vs1, pm;
      int mid, flen;
      if (gen_en) begin
        mid = s_hsb + s_sh;
        pm = (m_h >= mid);
        vs1 = s_il && ((m_v > s_s1b) || (m_v == s_s1b && pm)) &&
                      ((m_v < s_s1e) || (m_v == s_s1e && !pm));
        e_hs = int'(win(m_h, s_hsb, s_hse) ^ s_hi);
        e_vs = int'((win(m_v, s_s0b, s_s0e) || vs1) ^ s_vi);
        e_de = int'(win(m_h, s_ahb, s_ahe) &&
                    (win(m_v, s_a0b, s_a0e) || (s_il && win(m_v, s_a1b, s_a1e))));
        e_fd = int'(s_il && m_v >= s_a0e);
        e_pix = m_h; e_line = m_v;
      end else begin
        e_hs = int'(s_hi); e_vs = int'(s_vi);
        e_de = 0; e_fd = 0; e_pix = 0; e_line = 0;
      end
      flen = s_il ? s_a1e : s_a0e;
      lend = (m_h >= s_ahe - 1);
      fend = lend && (m_v >= flen - 1);
      if (!gen_en) begin m_h = 0; m_v = 0; end
      else if (lend) begin m_h = 0; m_v = fend ? 0 : m_v + 1; end
      else m_h = m_h + 1;
      if (!gen_en || fend) begin
        s_ahb = act_h_start; s_ahe = act_h_stop; s_hsb = hs_start; s_hse = hs_stop;
        s_sh = f1_vs_shift;
        s_a0b = f0_act_start; s_a0e = f0_act_stop; s_s0b = f0_vs_start; s_s0e = f0_vs_stop;
        s_a1b = f1_act_start; s_a1e = f1_act_stop; s_s1b = f1_vs_start; s_s1e = f1_vs_stop;
        s_il = ilace_en; s_hi = hs_inv; s_vi = vs_inv;
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    cmp("R3 hsync", int'(hsync_o), e_hs);
    cmp("R4 R6 vsync", int'(vsync_o), e_vs);
    cmp("R2 de", int'(de_o), e_de);
    cmp("R5 field", int'(field_o), e_fd);
    cmp("R1 pix", int'(pix_o), e_pix);
    cmp("R1 line", int'(line_o), e_line);
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_cfg(int il, int hi, int vi, int ahb, int ahe, int hsb, int hse, int sh,
                         int a0b, int a0e, int s0b, int s0e,
                         int a1b, int a1e, int s1b, int s1e);
    ilace_en = il[0]; hs_inv = hi[0]; vs_inv = vi[0];
    act_h_start = HW'(ahb); act_h_stop = HW'(ahe); hs_start = HW'(hsb); hs_stop = HW'(hse);
    f1_vs_shift = HW'(sh);
    f0_act_start = VW'(a0b); f0_act_stop = VW'(a0e); f0_vs_start = VW'(s0b); f0_vs_stop = VW'(s0e);
    f1_act_start = VW'(a1b); f1_act_stop = VW'(a1e); f1_vs_start = VW'(s1b); f1_vs_stop = VW'(s1e);
  endtask

  task automatic rand_cfg();
    int L, hb, hsb, hse, sh, il, F1, T, a0b, s0b, s0e, a1b, s1b, s1e;
    L = 12 + int'($urandom % 29);
    hb = int'($urandom % (L - 1));
    hsb = int'($urandom % (L - 1));
    hse = hsb + 1 + int'($urandom % (L - 1 - hsb));
    sh = int'($urandom % (L - hsb));
    il = int'($urandom % 2);
    if (il == 0) begin
      F1 = 4 + int'($urandom % 11);
      T = F1 + 3;
    end else begin
      F1 = 3 + int'($urandom % 6);
      T = F1 + 3 + int'($urandom % 6);
    end
    a0b = int'($urandom % (F1 - 1));
    s0b = int'($urandom % (F1 - 1));
    s0e = s0b + 1 + int'($urandom % (F1 - 1 - s0b));
    a1b = F1 + int'($urandom % (T - F1 - 1));
    s1b = F1 + int'($urandom % (T - F1 - 1));
    s1e = s1b + 1 + int'($urandom % (T - 1 - s1b));
    set_cfg(il, int'($urandom % 2), int'($urandom % 2), hb, L, hsb, hse, sh,
            a0b, F1, s0b, s0e, a1b, T, s1b, s1e);
  endtask

  // Wait for a reported position, then check one output (0 = vsync, 1 = field).
  task automatic probe(int ln, int px, int sel, int exp, string tag);
    bit hit = 1'b0;
    for (int i = 0; i < 600 && !hit; i++) begin
      @(negedge clk);
      if (int'(line_o) == ln && int'(pix_o) == px) begin
        hit = 1'b1;
        cmp(tag, sel == 0 ? int'(vsync_o) : int'(field_o), exp);
      end
    end
    if (!hit) cmp({tag, " position not reached"}, 0, 1);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp("R9 reset hsync", int'(hsync_o), 0);
    cmp("R9 reset de", int'(de_o), 0);
    cmp("R9 reset pix", int'(pix_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed interlaced frame: 20-pixel lines, mid-line point at pixel 10.
    set_cfg(1, 1, 0, 4, 20, 2, 5, 8, 1, 6, 0, 2, 7, 12, 6, 8);
    @(negedge clk);
    gen_en = 1'b1;
    probe(6, 9, 0, 0, "R6 vsync before mid on start line");
    probe(6, 10, 0, 1, "R6 vsync at mid on start line");
    probe(8, 9, 0, 1, "R6 vsync before mid on end line");
    probe(8, 10, 0, 0, "R6 vsync at mid on end line");
    probe(5, 19, 1, 0, "R5 field first field");
    probe(6, 0, 1, 1, "R5 field second field");

    // R8: stop and observe idle levels (hs_inv = 1 here).
    gen_en = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R8 idle hsync level", int'(hsync_o), 1);
    cmp("R8 idle de", int'(de_o), 0);
    cmp("R8 idle pix", int'(pix_o), 0);
    gen_en = 1'b1;
    @(negedge clk);
    cmp("R8 first pix after enable", int'(pix_o), 0);
    cmp("R8 first line after enable", int'(line_o), 0);

    // R7: shrink the line mid-frame; the running frame keeps 20 pixels.
    gen_en = 1'b0;
    set_cfg(0, 0, 1, 3, 20, 1, 4, 0, 2, 10, 1, 3, 0, 0, 0, 0);
    @(negedge clk);
    gen_en = 1'b1;
    repeat (45) @(negedge clk);
    act_h_stop = HW'(16);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 40 && !seen; i++) begin
        @(negedge clk);
        if (int'(pix_o) == 19) seen = 1'b1;
      end
      cmp("R7 old line length kept in running frame", int'(seen), 1);
    end
    repeat (300) @(negedge clk);

    // Random parameter sets, some applied live, some after a short stop.
    for (int it = 0; it < 45; it++) begin
      if ($urandom % 3 == 0) begin
        gen_en = 1'b0;
        repeat (1 + $urandom % 4) @(negedge clk);
        rand_cfg();
        @(negedge clk);
        gen_en = 1'b1;
      end else begin
        rand_cfg();
      end
      repeat (300 + $urandom % 900) @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(WD_CYC * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule